// File: doc/BRIEF.md
# Microcode Sequencer with Encoded Next-Address Field

This block is the control engine of a microcoded processor. A 6-bit micro-program counter selects one word of a combinational control store. Each word drives an 18-bit bundle of datapath control lines and carries a 3-bit jump code. The next micro-address is not stored in full. Jump logic works it out from the jump code, an incrementer, a small opcode dispatch table, the datapath condition flag and the memory busy flag.

The control store holds these routines:
- a shared three-step instruction fetch;
- register-register ALU;
- ALU with immediate;
- load word;
- jump-and-link;
- conditional branch;
- memory-to-memory add;
- an illegal-instruction entry that raises a trap for one step.

The datapath is not part of the block. It reaches the sequencer only through the opcode, condition and busy inputs, and it receives the control lines. All pins are plain control and status signals, with no handshake. The opcode input must hold steady from the start of fetch until the dispatch step.

Top module: `useq_engine`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the micro-PC becomes 0 (fetch entry), whether reset comes at start-up or in the middle of a routine.
- R2: Jump code "next" makes the micro-PC one greater on the following cycle.
- R3: Jump code "spin" keeps the micro-PC unchanged while `mem_busy_i` is high, and advances it by one in the cycle after busy is seen low.
- R4: Jump code "fetch" sends the micro-PC back to 0 on the following cycle.
- R5: Dispatch, at micro-address 2, loads the group start address from the opcode. The mapping is 5'h0C→3 (ALU), 5'h04→6 (ALU immediate), 5'h00→9 (load), 5'h1B→14 (jump-and-link), 5'h18→18 (branch) and 5'h0A→24 (memory add).
- R6: At branch step 20 (jump code "ffalse"), the next micro-address is 0 when `cond_i` is low and 21 when it is high. A taken branch then runs 21, 22, 23 and returns to 0.
- R7: Any opcode outside the R5 table dispatches to micro-address 31. There `trap_o` is high for exactly that one cycle, and the following cycle is micro-address 0 with `trap_o` low.
- R8: Fetch runs 0 (next), 1 (spin) and 2 (dispatch). At address 0 the control lines have bit 0 (memory-address load) and bit 1 (A load) set and the register-select field, bits 14:13, equal to 0 (PC). At address 1, bit 3 (instruction-register load) and bit 8 (memory enable) are set.
- R9: Memory add runs 24, 25 (spin), 26, 27 (spin), 28, 29 (spin) and 30 (fetch). Control bit 9 (memory write) is high at 29 and low at 25.
- R10: Load runs 9, 10, 11, 12 (spin), 13 (fetch). Jump-and-link runs 14 through 17. ALU and ALU-immediate each take three steps, ending with "fetch".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode_i | input | 5 | Major opcode of the current instruction |
| cond_i | input | 1 | Condition flag from the datapath comparator |
| mem_busy_i | input | 1 | Memory still working on the current access |
| upc_o | output | 6 | Current micro-PC |
| ctrl_o | output | 18 | Control lines of the current micro-word (bit 17 is trap) |
| trap_o | output | 1 | High while at the illegal-instruction entry |

## Verification
Every routine is run after a real fetch. The runs use busy lengths of zero, one, two and three cycles on the spin steps, which separates holding the micro-PC from advancing it too early or too late. The branch is run with the condition both low and high, so a swapped sense of "ffalse" shows up. Two unmapped opcodes check the trap path. A reset in mid-routine shows that reset overrides the jump code.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int UPC_W  = 6;
  localparam int OP_W   = 5;
  localparam int CTRL_W = 18;

  typedef enum logic [2:0] {
    J_NEXT   = 3'd0,
    J_SPIN   = 3'd1,
    J_FETCH  = 3'd2,
    J_DISP   = 3'd3,
    J_FTRUE  = 3'd4,
    J_FFALSE = 3'd5
  } ujump_e;

  // control line positions
  localparam int B_MA    = 0;
  localparam int B_A     = 1;
  localparam int B_B     = 2;
  localparam int B_IR    = 3;
  localparam int B_PC    = 4;
  localparam int B_REGEN = 5;
  localparam int B_REGWR = 6;
  localparam int B_ALUEN = 7;
  localparam int B_MEMEN = 8;
  localparam int B_MEMWR = 9;
  localparam int B_IMMEN = 10;
  localparam int B_IMMSL = 11; // 2 bits
  localparam int B_RSEL  = 13; // 2 bits
  localparam int B_ALUOP = 15; // 2 bits
  localparam int B_TRAP  = 17;

  localparam logic [CTRL_W-1:0] C_MA    = CTRL_W'(1) << B_MA;
  localparam logic [CTRL_W-1:0] C_A     = CTRL_W'(1) << B_A;
  localparam logic [CTRL_W-1:0] C_B     = CTRL_W'(1) << B_B;
  localparam logic [CTRL_W-1:0] C_IR    = CTRL_W'(1) << B_IR;
  localparam logic [CTRL_W-1:0] C_PC    = CTRL_W'(1) << B_PC;
  localparam logic [CTRL_W-1:0] C_REGEN = CTRL_W'(1) << B_REGEN;
  localparam logic [CTRL_W-1:0] C_REGWR = CTRL_W'(1) << B_REGWR;
  localparam logic [CTRL_W-1:0] C_ALUEN = CTRL_W'(1) << B_ALUEN;
  localparam logic [CTRL_W-1:0] C_MEMEN = CTRL_W'(1) << B_MEMEN;
  localparam logic [CTRL_W-1:0] C_MEMWR = CTRL_W'(1) << B_MEMWR;
  localparam logic [CTRL_W-1:0] C_IMMEN = CTRL_W'(1) << B_IMMEN;
  localparam logic [CTRL_W-1:0] C_TRAP  = CTRL_W'(1) << B_TRAP;

  localparam logic [CTRL_W-1:0] IMM_I = CTRL_W'(0) << B_IMMSL;
  localparam logic [CTRL_W-1:0] IMM_J = CTRL_W'(1) << B_IMMSL;
  localparam logic [CTRL_W-1:0] IMM_B = CTRL_W'(2) << B_IMMSL;

  localparam logic [CTRL_W-1:0] RS_PC  = CTRL_W'(0) << B_RSEL;
  localparam logic [CTRL_W-1:0] RS_S1  = CTRL_W'(1) << B_RSEL;
  localparam logic [CTRL_W-1:0] RS_S2  = CTRL_W'(2) << B_RSEL;
  localparam logic [CTRL_W-1:0] RS_RD  = CTRL_W'(3) << B_RSEL;

  localparam logic [CTRL_W-1:0] OP_FN   = CTRL_W'(0) << B_ALUOP;
  localparam logic [CTRL_W-1:0] OP_ADD  = CTRL_W'(1) << B_ALUOP;
  localparam logic [CTRL_W-1:0] OP_INC4 = CTRL_W'(2) << B_ALUOP;
  localparam logic [CTRL_W-1:0] OP_DEC4 = CTRL_W'(3) << B_ALUOP;

  // micro-address map
  localparam int UA_FETCH0 = 0;
  localparam int UA_ALU    = 3;
  localparam int UA_ALUI   = 6;
  localparam int UA_LW     = 9;
  localparam int UA_JAL    = 14;
  localparam int UA_BR     = 18;
  localparam int UA_MMA    = 24;
  localparam int UA_ILL    = 31;

  // opcode values
  localparam logic [OP_W-1:0] OPC_ALU  = 5'h0C;
  localparam logic [OP_W-1:0] OPC_ALUI = 5'h04;
  localparam logic [OP_W-1:0] OPC_LW   = 5'h00;
  localparam logic [OP_W-1:0] OPC_JAL  = 5'h1B;
  localparam logic [OP_W-1:0] OPC_BR   = 5'h18;
  localparam logic [OP_W-1:0] OPC_MMA  = 5'h0A;
endpackage

// File: rtl/useq_store.sv
`timescale 1ns/1ps
module useq_store
  import useq_pkg::*;
#(
  parameter int UPC_WIDTH  = UPC_W,
  parameter int CTRL_WIDTH = CTRL_W
) (
  input  logic [UPC_WIDTH-1:0]  upc,
  output logic [CTRL_WIDTH-1:0] ctrl,
  output ujump_e                jump
);
  logic [CTRL_W-1:0] word;

  always_comb begin
    word = '0;
    jump = J_FETCH;
    case (int'(upc))
      // shared fetch
      0:  begin word = C_MA | C_A | C_REGEN | RS_PC;          jump = J_NEXT;   end
      1:  begin word = C_IR | C_MEMEN;                        jump = J_SPIN;   end
      2:  begin word = C_PC | C_ALUEN | OP_INC4;              jump = J_DISP;   end
      // register-register ALU
      3:  begin word = C_A | C_REGEN | RS_S1;                 jump = J_NEXT;   end
      4:  begin word = C_B | C_REGEN | RS_S2;                 jump = J_NEXT;   end
      5:  begin word = C_REGEN | C_REGWR | RS_RD | C_ALUEN | OP_FN; jump = J_FETCH; end
      // ALU immediate
      6:  begin word = C_A | C_REGEN | RS_S1;                 jump = J_NEXT;   end
      7:  begin word = C_B | C_IMMEN | IMM_I;                 jump = J_NEXT;   end
      8:  begin word = C_REGEN | C_REGWR | RS_RD | C_ALUEN | OP_FN; jump = J_FETCH; end
      // load word
      9:  begin word = C_A | C_REGEN | RS_S1;                 jump = J_NEXT;   end
      10: begin word = C_B | C_IMMEN | IMM_I;                 jump = J_NEXT;   end
      11: begin word = C_MA | C_ALUEN | OP_ADD;               jump = J_NEXT;   end
      12: begin word = C_REGEN | C_REGWR | RS_RD | C_MEMEN;   jump = J_SPIN;   end
      13: begin word = '0;                                    jump = J_FETCH;  end
      // jump and link
      14: begin word = C_REGEN | C_REGWR | RS_RD;             jump = J_NEXT;   end
      15: begin word = C_A | C_ALUEN | OP_DEC4;               jump = J_NEXT;   end
      16: begin word = C_B | C_IMMEN | IMM_J;                 jump = J_NEXT;   end
      17: begin word = C_PC | C_ALUEN | OP_ADD;               jump = J_FETCH;  end
      // conditional branch
      18: begin word = C_A | C_REGEN | RS_S1;                 jump = J_NEXT;   end
      19: begin word = C_B | C_REGEN | RS_S2;                 jump = J_NEXT;   end
      20: begin word = C_A | C_REGEN | RS_PC;                 jump = J_FFALSE; end
      21: begin word = C_A | C_ALUEN | OP_DEC4;               jump = J_NEXT;   end
      22: begin word = C_B | C_IMMEN | IMM_B;                 jump = J_NEXT;   end
      23: begin word = C_PC | C_ALUEN | OP_ADD;               jump = J_FETCH;  end
      // memory to memory add
      24: begin word = C_MA | C_REGEN | RS_S1;                jump = J_NEXT;   end
      25: begin word = C_A | C_MEMEN;                         jump = J_SPIN;   end
      26: begin word = C_MA | C_REGEN | RS_S2;                jump = J_NEXT;   end
      27: begin word = C_B | C_MEMEN;                         jump = J_SPIN;   end
      28: begin word = C_MA | C_REGEN | RS_RD;                jump = J_NEXT;   end
      29: begin word = C_MEMEN | C_MEMWR | C_ALUEN | OP_FN;   jump = J_SPIN;   end
      30: begin word = '0;                                    jump = J_FETCH;  end
      // illegal instruction
      31: begin word = C_TRAP;                                jump = J_FETCH;  end
      default: begin word = '0;                               jump = J_FETCH;  end
    endcase
  end

  assign ctrl = CTRL_WIDTH'(word);
endmodule

// File: rtl/useq_dispatch.sv
`timescale 1ns/1ps
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int UPC_WIDTH = UPC_W,
  parameter int OP_WIDTH  = OP_W
) (
  input  logic [OP_WIDTH-1:0]  opcode,
  output logic [UPC_WIDTH-1:0] start
);
  always_comb begin
    case (OP_W'(opcode))
      OPC_ALU:  start = UPC_WIDTH'(UA_ALU);
      OPC_ALUI: start = UPC_WIDTH'(UA_ALUI);
      OPC_LW:   start = UPC_WIDTH'(UA_LW);
      OPC_JAL:  start = UPC_WIDTH'(UA_JAL);
      OPC_BR:   start = UPC_WIDTH'(UA_BR);
      OPC_MMA:  start = UPC_WIDTH'(UA_MMA);
      default:  start = UPC_WIDTH'(UA_ILL);
    endcase
  end
endmodule

// File: rtl/useq_next.sv
`timescale 1ns/1ps
module useq_next
  import useq_pkg::*;
#(
  parameter int UPC_WIDTH = UPC_W
) (
  input  ujump_e               jump,
  input  logic [UPC_WIDTH-1:0] upc,
  input  logic [UPC_WIDTH-1:0] start,
  input  logic                 cond,
  input  logic                 busy,
  output logic [UPC_WIDTH-1:0] nxt
);
  localparam logic [UPC_WIDTH-1:0] ENTRY = UPC_WIDTH'(UA_FETCH0);
  logic [UPC_WIDTH-1:0] inc;

  assign inc = upc + UPC_WIDTH'(1);

  always_comb begin
    case (jump)
      J_NEXT:   nxt = inc;
      J_SPIN:   nxt = busy ? upc : inc;
      J_FETCH:  nxt = ENTRY;
      J_DISP:   nxt = start;
      J_FTRUE:  nxt = cond ? ENTRY : inc;
      J_FFALSE: nxt = cond ? inc : ENTRY;
      default:  nxt = ENTRY;
    endcase
  end
endmodule

// File: rtl/useq_engine.sv
`timescale 1ns/1ps
module useq_engine
  import useq_pkg::*;
#(
  parameter int UPC_WIDTH  = UPC_W,
  parameter int OP_WIDTH   = OP_W,
  parameter int CTRL_WIDTH = CTRL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OP_WIDTH-1:0]   opcode_i,
  input  logic                  cond_i,
  input  logic                  mem_busy_i,
  output logic [UPC_WIDTH-1:0]  upc_o,
  output logic [CTRL_WIDTH-1:0] ctrl_o,
  output logic                  trap_o
);
  logic [UPC_WIDTH-1:0] upc_q;
  logic [UPC_WIDTH-1:0] upc_d;
  logic [UPC_WIDTH-1:0] grp_start;
  ujump_e               cur_jump;

  useq_store #(.UPC_WIDTH(UPC_WIDTH), .CTRL_WIDTH(CTRL_WIDTH)) u_store (
    .upc  (upc_q),
    .ctrl (ctrl_o),
    .jump (cur_jump)
  );

  useq_dispatch #(.UPC_WIDTH(UPC_WIDTH), .OP_WIDTH(OP_WIDTH)) u_disp (
    .opcode (opcode_i),
    .start  (grp_start)
  );

  useq_next #(.UPC_WIDTH(UPC_WIDTH)) u_next (
    .jump  (cur_jump),
    .upc   (upc_q),
    .start (grp_start),
    .cond  (cond_i),
    .busy  (mem_busy_i),
    .nxt   (upc_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) upc_q <= UPC_WIDTH'(UA_FETCH0);
    else        upc_q <= upc_d;
  end

  assign upc_o  = upc_q;
  assign trap_o = ctrl_o[B_TRAP];
endmodule

// File: rtl/useq_engine_chk.sv
`timescale 1ns/1ps
module useq_engine_chk
  import useq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] upc,
  input ujump_e     jump,
  input logic       cond,
  input logic       busy,
  input logic       trap
);
  assert_next_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (jump == J_NEXT) |=> (upc == 6'($past(upc) + 6'd1)));

  assert_spin_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (jump == J_SPIN && busy) |=> $stable(upc));

  assert_spin_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (jump == J_SPIN && !busy) |=> (upc == 6'($past(upc) + 6'd1)));

  assert_fetch_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (jump == J_FETCH) |=> (upc == 6'd0));

  assert_ffalse_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (jump == J_FFALSE && !cond) |=> (upc == 6'd0));

  assert_trap_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (upc == 6'd31));

  assert_trap_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (!trap && upc == 6'd0));
endmodule

bind useq_engine useq_engine_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .upc   (upc_o),
  .jump  (cur_jump),
  .cond  (cond_i),
  .busy  (mem_busy_i),
  .trap  (trap_o)
);

// File: tb/useq_engine_bench.sv
`timescale 1ns/1ps
module useq_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  opcode_i = 5'h0;
  logic        cond_i = 1'b0;
  logic        mem_busy_i = 1'b0;
  logic [5:0]  upc_o;
  logic [17:0] ctrl_o;
  logic        trap_o;

  useq_engine u_useq_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode_i   (opcode_i),
    .cond_i     (cond_i),
    .mem_busy_i (mem_busy_i),
    .upc_o      (upc_o),
    .ctrl_o     (ctrl_o),
    .trap_o     (trap_o)
  );

  always #10 clk = ~clk; // 50 MHz

  typedef struct {
    logic [5:0]  upc;
    logic        trap;
    logic [17:0] m;
    logic [17:0] v;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   errs = 0;
  int   checks = 0;
  bit   done = 0;

  localparam logic [17:0] M_WR   = 18'h00200;
  localparam logic [17:0] M_F0   = 18'h06003;
  localparam logic [17:0] V_F0   = 18'h00003;
  localparam logic [17:0] M_F1   = 18'h00108;

  // monitor: compares in mid-cycle
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (upc_o !== e.upc || trap_o !== e.trap || (ctrl_o & e.m) !== e.v) begin
        errs++;
        $display("FAIL %s: upc=%0d trap=%0b ctrl=%h | expected upc=%0d trap=%0b ctrl&%h=%h",
                 e.tag, upc_o, trap_o, ctrl_o, e.upc, e.trap, e.m, e.v);
      end
    end
  end

  // driver: one cycle, inputs and expected state of that cycle
  task automatic st(input logic [5:0] a, input logic b = 1'b0, input logic c = 1'b0,
                    input string tag = "R2", input logic tr = 1'b0,
                    input logic [17:0] m = 18'h0, input logic [17:0] v = 18'h0,
                    input logic rv = 1'b1);
    exp_t e;
    @(posedge clk);
    #1;
    rst_n = rv;
    mem_busy_i = b;
    cond_i = c;
    e.upc = a; e.trap = tr; e.m = m; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic spin_at(input logic [5:0] a, input int nb, input string tag,
                         input logic [17:0] m = 18'h0, input logic [17:0] v = 18'h0);
    for (int i = 0; i < nb; i++) st(a, 1'b1, 1'b0, tag, 1'b0, m, v);
    st(a, 1'b0, 1'b0, tag, 1'b0, m, v);
  endtask

  task automatic fetch_seq(input logic [4:0] op, input int nb);
    opcode_i = op;
    st(6'd0, 1'b0, 1'b0, "R8", 1'b0, M_F0, V_F0);
    spin_at(6'd1, nb, "R8", M_F1, M_F1);
    st(6'd2, 1'b0, 1'b0, "R5");
  endtask

  initial begin : drive
    // R1: held in reset
    st(6'd0, 1'b0, 1'b0, "R1", 1'b0, 18'h0, 18'h0, 1'b0);
    st(6'd0, 1'b0, 1'b0, "R1", 1'b0, 18'h0, 18'h0, 1'b0);
    st(6'd0, 1'b0, 1'b0, "R1", 1'b0, 18'h0, 18'h0, 1'b0);

    // ALU (R5, R10, R4)
    fetch_seq(5'h0C, 0);
    st(6'd3, 1'b0, 1'b0, "R5");
    st(6'd4, 1'b0, 1'b0, "R10");
    st(6'd5, 1'b0, 1'b0, "R10");

    // ALU immediate, busy 2 on fetch (R3)
    fetch_seq(5'h04, 2);
    st(6'd6, 1'b0, 1'b0, "R5");
    st(6'd7, 1'b0, 1'b0, "R10");
    st(6'd8, 1'b0, 1'b0, "R10");

    // load word
    fetch_seq(5'h00, 1);
    st(6'd9, 1'b0, 1'b0, "R5");
    st(6'd10, 1'b0, 1'b0, "R10");
    st(6'd11, 1'b0, 1'b0, "R10");
    spin_at(6'd12, 3, "R3");
    st(6'd13, 1'b0, 1'b0, "R10");

    // jump and link
    fetch_seq(5'h1B, 0);
    st(6'd14, 1'b0, 1'b0, "R5");
    st(6'd15, 1'b0, 1'b0, "R10");
    st(6'd16, 1'b0, 1'b0, "R10");
    st(6'd17, 1'b0, 1'b0, "R10");

    // branch, not taken (R6)
    fetch_seq(5'h18, 0);
    st(6'd18, 1'b0, 1'b0, "R5");
    st(6'd19, 1'b0, 1'b0, "R2");
    st(6'd20, 1'b0, 1'b0, "R6");

    // branch, taken (R6)
    fetch_seq(5'h18, 1);
    st(6'd18, 1'b0, 1'b0, "R5");
    st(6'd19, 1'b0, 1'b0, "R2");
    st(6'd20, 1'b0, 1'b1, "R6");
    st(6'd21, 1'b0, 1'b0, "R6");
    st(6'd22, 1'b0, 1'b0, "R6");
    st(6'd23, 1'b0, 1'b0, "R6");

    // memory to memory add (R9, R3)
    fetch_seq(5'h0A, 0);
    st(6'd24, 1'b0, 1'b0, "R5");
    spin_at(6'd25, 2, "R9", M_WR, 18'h0);
    st(6'd26, 1'b0, 1'b0, "R9");
    spin_at(6'd27, 0, "R9");
    st(6'd28, 1'b0, 1'b0, "R9");
    spin_at(6'd29, 1, "R9", M_WR, M_WR);
    st(6'd30, 1'b0, 1'b0, "R9");

    // illegal opcodes (R7)
    fetch_seq(5'h1F, 0);
    st(6'd31, 1'b0, 1'b0, "R7", 1'b1);
    fetch_seq(5'h01, 0);
    st(6'd31, 1'b0, 1'b0, "R7", 1'b1);

    // reset in mid-routine (R1)
    fetch_seq(5'h0C, 0);
    st(6'd3, 1'b0, 1'b0, "R5");
    st(6'd4, 1'b0, 1'b0, "R1", 1'b0, 18'h0, 18'h0, 1'b0);
    st(6'd0, 1'b0, 1'b0, "R1", 1'b0, 18'h0, 18'h0, 1'b0);
    st(6'd0, 1'b0, 1'b0, "R1");
    st(6'd1, 1'b0, 1'b0, "R1");
    st(6'd2, 1'b0, 1'b0, "R5");
    st(6'd3, 1'b0, 1'b0, "R5");
    st(6'd4, 1'b0, 1'b0, "R2");
    st(6'd5, 1'b0, 1'b0, "R2");
    st(6'd0, 1'b0, 1'b0, "R4");

    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      errs++;
      $display("FAIL R2: %0d expected items left, expected 0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL R1: watchdog expired, done=%0b expected 1", done);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule